// File: doc/BRIEF.md
# Register-Mapped Serial Flash Host Front End

This block lets software run a serial flash bus one 32-bit word at a time through a small register window on a 32-bit APB-style bus. Software sets up a configuration register (manual chip select control and the idle level of the data-out line), turns the controller on through an enable register, and then starts each burst by writing the word to be sent. There are four aliases of the transmit data register, and the alias written sets the burst length: one, two, three or four bytes.

A burst shifts its bytes out on a single data-out line in SPI mode 0 (clock idles low, data sampled on the rising edge) and collects the same number of bytes from the data-in line. The received bytes are left-aligned in the receive word, so that software shifts right by 8*(4-n) to use an n-byte result. Reading the receive register pops the word. Status bits report the transmit and receive state and a sticky overflow flag. An interrupt line is the OR of the visible status bits, each gated by its own signal enable bit.

Top module: `spi_fe_top`

## Requirements
- R1: After reset, chip select is high (inactive), the serial clock is low, irq is 0, and the configuration, enable, status-enable and signal-enable registers all read 0.
- R2: Register offsets: configuration 0x00 (bit 0 chip-select assert, bit 1 manual chip-select enable, bit 16 idle data level; other bits read 0), status 0x04, status enable 0x08 (bits 4:0), signal enable 0x0C (bits 4:0), controller enable 0x10 (bit 0). Status reads as raw status AND status enable, where raw bit 0 = transmit empty, bit 1 = transmit not full, bit 2 = receive not empty, bit 3 = receive not full, bit 4 = overflow.
- R3: spi_cs_n is low only while configuration bits 1 and 0 are both 1 and the enable bit is 1, and it follows them one clock later.
- R4: A write to the transmit alias at 0x14 + 4*k, with k from 0 to 3, starts a burst of k bytes (k = 0 gives 4 bytes) if the controller is enabled and idle. It produces exactly 8 rising serial clock edges per byte.
- R5: Transmit bytes go out lowest byte first (bits 7:0 first), each byte most significant bit first. Data-out changes while the clock is low, and data-in is sampled on the rising clock edge.
- R6: After an n-byte burst, the receive word at 0x24 holds the i-th received byte (counting from 0) in bits 8*(4-n+i)+7 down to 8*(4-n+i), and zeros below.
- R7: A read of 0x24 pops the word: receive-not-empty (status bit 2) is 0 afterwards.
- R8: Whenever no burst is running, spi_mosi equals configuration bit 16.
- R9: Writing 0 to bit 0 of the enable register aborts a running burst (the serial clock returns low at once), deasserts chip select, and discards any unread receive word.
- R10: A transmit alias write while a burst is running is ignored and sets the sticky overflow status bit 4. Writing 1 to status bit 4 clears it; writing to the live bits 3:0 has no effect.
- R11: irq is the OR over all five bits of (raw status AND status enable AND signal enable).
- R12: A transmit alias write while the controller is disabled starts no burst and does not set overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions take for granted that each bus access is a setup cycle followed by one access cycle, with no wait state. They also assume that spi_miso changes only while the serial clock is low. The bench keeps to this through a single access task that always drives the two-cycle sequence, and through a device model that moves its data-in bit only on the falling serial clock edge. The bench never issues an enable write in the same cycle as a transmit write, because both share the one bus.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
   localparam logic [7:0] OFF_CFG    = 8'h00;
   localparam logic [7:0] OFF_STS    = 8'h04;
   localparam logic [7:0] OFF_STS_EN = 8'h08;
   localparam logic [7:0] OFF_SIG_EN = 8'h0C;
   localparam logic [7:0] OFF_EN     = 8'h10;
   localparam logic [7:0] OFF_TX0    = 8'h14;
   localparam logic [7:0] OFF_RX     = 8'h24;

   localparam int STS_W        = 5;
   localparam int ST_TX_EMPTY  = 0;
   localparam int ST_TX_NFULL  = 1;
   localparam int ST_RX_NEMPTY = 2;
   localparam int ST_RX_NFULL  = 3;
   localparam int ST_OVF       = 4;

   localparam int CFG_CS_ASSERT = 0;
   localparam int CFG_CS_MAN    = 1;
   localparam int CFG_IDLE      = 16;

   typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_state_e;
endpackage

// File: rtl/spi_fe_shifter.sv
module spi_fe_shifter
   import spi_fe_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int HALF_DIV = 2,
   localparam int BYTES   = WORD_W / 8,
   localparam int NB_W    = $clog2(BYTES + 1),
   localparam int BITS_W  = $clog2(WORD_W + 1),
   localparam int CNT_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NB_W-1:0]   nbytes,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              abort,
   input  logic              idle_lvl,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rx_word
);
   sh_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BITS_W-1:0] bits_left;
   logic [WORD_W-1:0] sh;
   logic [WORD_W-1:0] tx_swap;
   logic [7:0]        rx_byte;
   logic              half_end;

   // byte order reversal: lowest byte leaves first, MSB first inside a byte
   for (genvar b = 0; b < BYTES; b++) begin : g_swap
      assign tx_swap[WORD_W-1-8*b -: 8] = tx_word[8*b +: 8];
   end

   assign half_end = (cnt == CNT_W'(HALF_DIV - 1));
   assign done     = (state == SH_HIGH) && half_end && (bits_left == BITS_W'(1)) && !abort;
   assign busy     = (state != SH_IDLE);
   assign mosi     = (state == SH_IDLE) ? idle_lvl : sh[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SH_IDLE;
         cnt       <= '0;
         bits_left <= '0;
         sh        <= '0;
         rx_byte   <= '0;
         rx_word   <= '0;
         sclk      <= 1'b0;
      end else if (abort) begin
         state <= SH_IDLE;
         cnt   <= '0;
         sclk  <= 1'b0;
      end else begin
         unique case (state)
            SH_IDLE: begin
               if (start) begin
                  sh        <= tx_swap;
                  bits_left <= BITS_W'(nbytes) << 3;
                  rx_word   <= '0;
                  cnt       <= '0;
                  state     <= SH_LOW;
               end
            end
            SH_LOW: begin
               if (half_end) begin
                  cnt     <= '0;
                  sclk    <= 1'b1;
                  state   <= SH_HIGH;
                  rx_byte <= {rx_byte[6:0], miso};
                  if (bits_left[2:0] == 3'd1)
                     rx_word <= {rx_byte[6:0], miso, rx_word[WORD_W-1:8]};
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            SH_HIGH: begin
               if (half_end) begin
                  cnt  <= '0;
                  sclk <= 1'b0;
                  if (bits_left == BITS_W'(1)) begin
                     state     <= SH_IDLE;
                     bits_left <= '0;
                  end else begin
                     state     <= SH_LOW;
                     sh        <= sh << 1;
                     bits_left <= bits_left - BITS_W'(1);
                  end
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: state <= SH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_fe_regs.sv
module spi_fe_regs
   import spi_fe_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int WORD_W  = 32,
   localparam int BYTES  = WORD_W / 8,
   localparam int NB_W   = $clog2(BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [WORD_W-1:0] pwdata,
   output logic [WORD_W-1:0] prdata,
   input  logic              busy,
   input  logic              done,
   input  logic [WORD_W-1:0] rx_word,
   output logic              start,
   output logic [NB_W-1:0]   nbytes,
   output logic [WORD_W-1:0] tx_word,
   output logic              abort,
   output logic              idle_lvl,
   output logic              ctl_en,
   output logic              man_en,
   output logic              man_as,
   output logic              irq
);
   logic             wr, rd, tx_hit, rx_pop;
   logic [BYTES-1:0] alias_hit;
   logic [STS_W-1:0] sts_en, sig_en, raw, vis;
   logic             ovf, rx_valid;
   logic [WORD_W-1:0] rx_q;

   assign wr = psel && penable && pwrite;
   assign rd = psel && penable && !pwrite;

   for (genvar k = 0; k < BYTES; k++) begin : g_alias
      assign alias_hit[k] = wr && (paddr == ADDR_W'(OFF_TX0 + 8'(4 * k)));
   end

   always_comb begin
      nbytes = '0;
      for (int k = 0; k < BYTES; k++)
         if (alias_hit[k]) nbytes = (k == 0) ? NB_W'(BYTES) : NB_W'(k);
   end

   assign tx_hit  = |alias_hit;
   assign start   = tx_hit && ctl_en && !busy;
   assign tx_word = pwdata;
   assign abort   = wr && (paddr == ADDR_W'(OFF_EN)) && !pwdata[0];
   assign rx_pop  = rd && (paddr == ADDR_W'(OFF_RX));

   always_comb begin
      raw = '0;
      raw[ST_TX_EMPTY]  = !busy;
      raw[ST_TX_NFULL]  = !busy;
      raw[ST_RX_NEMPTY] = rx_valid;
      raw[ST_RX_NFULL]  = !rx_valid;
      raw[ST_OVF]       = ovf;
   end
   assign vis = raw & sts_en;
   assign irq = |(vis & sig_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         man_as   <= 1'b0;
         man_en   <= 1'b0;
         idle_lvl <= 1'b0;
         ctl_en   <= 1'b0;
         sts_en   <= '0;
         sig_en   <= '0;
         ovf      <= 1'b0;
         rx_valid <= 1'b0;
         rx_q     <= '0;
      end else begin
         if (wr && paddr == ADDR_W'(OFF_CFG)) begin
            man_as   <= pwdata[CFG_CS_ASSERT];
            man_en   <= pwdata[CFG_CS_MAN];
            idle_lvl <= pwdata[CFG_IDLE];
         end
         if (wr && paddr == ADDR_W'(OFF_EN))     ctl_en <= pwdata[0];
         if (wr && paddr == ADDR_W'(OFF_STS_EN)) sts_en <= pwdata[STS_W-1:0];
         if (wr && paddr == ADDR_W'(OFF_SIG_EN)) sig_en <= pwdata[STS_W-1:0];
         if (tx_hit && ctl_en && busy)
            ovf <= 1'b1;
         else if (wr && paddr == ADDR_W'(OFF_STS) && pwdata[ST_OVF])
            ovf <= 1'b0;
         if (abort) begin
            rx_valid <= 1'b0;
         end else if (done) begin
            rx_valid <= 1'b1;
            rx_q     <= rx_word;
         end else if (rx_pop) begin
            rx_valid <= 1'b0;
         end
      end
   end

   always_comb begin
      prdata = '0;
      if (paddr == ADDR_W'(OFF_CFG)) begin
         prdata[CFG_CS_ASSERT] = man_as;
         prdata[CFG_CS_MAN]    = man_en;
         prdata[CFG_IDLE]      = idle_lvl;
      end else if (paddr == ADDR_W'(OFF_STS))    prdata[STS_W-1:0] = vis;
      else if (paddr == ADDR_W'(OFF_STS_EN))     prdata[STS_W-1:0] = sts_en;
      else if (paddr == ADDR_W'(OFF_SIG_EN))     prdata[STS_W-1:0] = sig_en;
      else if (paddr == ADDR_W'(OFF_EN))         prdata[0] = ctl_en;
      else if (paddr == ADDR_W'(OFF_RX))         prdata = rx_q;
   end
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top #(
   parameter int ADDR_W   = 8,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              irq
);
   localparam int WORD_W = 32;
   localparam int BYTES  = WORD_W / 8;
   localparam int NB_W   = $clog2(BYTES + 1);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must cover offsets up to 0x24");
   end

   logic              start, abort, busy, done, idle_lvl;
   logic              ctl_en, man_en, man_as;
   logic [NB_W-1:0]   nbytes;
   logic [WORD_W-1:0] tx_word, rx_word;

   spi_fe_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .busy(busy), .done(done), .rx_word(rx_word),
      .start(start), .nbytes(nbytes), .tx_word(tx_word), .abort(abort),
      .idle_lvl(idle_lvl), .ctl_en(ctl_en), .man_en(man_en), .man_as(man_as),
      .irq(irq)
   );

   spi_fe_shifter #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .nbytes(nbytes), .tx_word(tx_word),
      .abort(abort), .idle_lvl(idle_lvl), .miso(spi_miso),
      .sclk(spi_sclk), .mosi(spi_mosi), .busy(busy), .done(done), .rx_word(rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) spi_cs_n <= 1'b1;
      else        spi_cs_n <= !(ctl_en && man_en && man_as);
   end
endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk (
   input logic clk,
   input logic rst_n,
   input logic spi_cs_n,
   input logic spi_sclk,
   input logic ctl_en,
   input logic man_en,
   input logic man_as,
   input logic busy,
   input logic start,
   input logic abort,
   input logic done
);
   assert_cs_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> $past(ctl_en && man_en && man_as));

   assert_sclk_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> busy);

   assert_abort_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !spi_sclk));

   assert_abort_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> ##1 spi_cs_n);

   assert_start_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

bind spi_fe_top spi_fe_chk u_chk (
   .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
   .ctl_en(ctl_en), .man_en(man_en), .man_as(man_as), .busy(busy),
   .start(start), .abort(abort), .done(done)
);

// File: tb/test_spi_fe_top.sv
module test_spi_fe_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        spi_sclk, spi_cs_n, spi_mosi, irq;
   logic        spi_miso;

   int errors = 0;
   int checks = 0;

   logic [31:0] slv_sh = '0;
   logic [31:0] slv_in = '0;
   int          slv_cnt = 0;

   logic [31:0] exp_q[$];
   logic [31:0] act_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   spi_fe_top i_spi_fe_top (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .irq(irq)
   );

   // device model: sample data-out on rising edge, move data-in on falling edge
   assign spi_miso = slv_sh[31];
   always @(posedge spi_sclk) begin
      slv_in  = {slv_in[30:0], spi_mosi};
      slv_cnt = slv_cnt + 1;
   end
   always @(negedge spi_sclk) slv_sh = {slv_sh[30:0], 1'b1};

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         wait (act_q.size() != 0);
         check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
      end
   end

   task automatic apb_wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(negedge clk); penable = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(negedge clk); penable = 1; #1 d = prdata;
      @(negedge clk); psel = 0; penable = 0;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      int guard = 0;
      do begin
         apb_rd(8'h04, s);
         guard++;
      end while (!s[0] && guard < 1000);
   endtask

   task automatic slv_load(logic [31:0] pat);
      slv_sh = pat; slv_in = '0; slv_cnt = 0;
   endtask

   // driver: pushes expected items, runs the burst, hands results to the monitor
   task automatic burst(int k, logic [31:0] txw, logic [31:0] pat);
      int n = (k == 0) ? 4 : k;
      logic [31:0] erx = '0, emo = '0, r, s;
      for (int i = 0; i < n; i++) begin
         erx[8*(4-n+i) +: 8] = pat[31-8*i -: 8];
         emo[8*(n-1-i) +: 8] = txw[8*i +: 8];
      end
      exp_q.push_back(erx);          tag_q.push_back($sformatf("R6 rx k=%0d", k));
      exp_q.push_back(emo);          tag_q.push_back($sformatf("R5 mosi k=%0d", k));
      exp_q.push_back(32'(8 * n));   tag_q.push_back($sformatf("R4 edges k=%0d", k));
      slv_load(pat);
      apb_wr(8'(8'h14 + 4 * k), txw);
      wait_idle();
      apb_rd(8'h24, r);
      act_q.push_back(r);
      act_q.push_back(slv_in);
      act_q.push_back(32'(slv_cnt));
      apb_rd(8'h04, s);
      check("R7 rx popped", {31'b0, s[2]}, 32'h0);
   endtask

   logic [31:0] d;

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 cs_n", {31'b0, spi_cs_n}, 32'h1);
      check("R1 sclk", {31'b0, spi_sclk}, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      apb_rd(8'h00, d); check("R1 cfg", d, 32'h0);
      apb_rd(8'h10, d); check("R1 en", d, 32'h0);
      apb_rd(8'h04, d); check("R1 status masked", d, 32'h0);
      // R2 map and status mask
      apb_wr(8'h08, 32'hFFFF_FFFF);
      apb_rd(8'h08, d); check("R2 sts_en", d, 32'h1F);
      apb_rd(8'h04, d); check("R2 idle status", d, 32'h0B);
      apb_wr(8'h00, 32'hFFFF_FFFF);
      apb_rd(8'h00, d); check("R2 cfg bits", d, 32'h0001_0003);
      apb_wr(8'h00, 32'h0001_0002);
      // R8 idle level
      @(negedge clk); check("R8 mosi idle 1", {31'b0, spi_mosi}, 32'h1);
      apb_wr(8'h00, 32'h0000_0002);
      @(negedge clk); check("R8 mosi idle 0", {31'b0, spi_mosi}, 32'h0);
      apb_wr(8'h00, 32'h0001_0002);
      // R12 disabled write
      slv_load(32'h0);
      apb_wr(8'h14, 32'h1234_5678);
      repeat (20) @(negedge clk);
      check("R12 no edges", 32'(slv_cnt), 32'h0);
      apb_rd(8'h04, d); check("R12 status", d, 32'h0B);
      // R3 chip select
      apb_wr(8'h10, 32'h1);
      repeat (2) @(negedge clk);
      check("R3 cs inactive without assert", {31'b0, spi_cs_n}, 32'h1);
      apb_wr(8'h00, 32'h0001_0003);
      repeat (2) @(negedge clk);
      check("R3 cs active", {31'b0, spi_cs_n}, 32'h0);
      apb_wr(8'h10, 32'h0);
      repeat (2) @(negedge clk);
      check("R3 cs off with en 0", {31'b0, spi_cs_n}, 32'h1);
      apb_wr(8'h10, 32'h1);
      // R4 R5 R6 R7 bursts
      burst(1, 32'h0000_00A5, 32'h3C00_0000);
      burst(2, 32'h0000_81F0, 32'hC3E1_0000);
      burst(3, 32'h0055_AA0F, 32'h1234_5600);
      burst(0, 32'hDEAD_BEEF, 32'h9876_5432);
      burst(0, 32'hFFFF_FFFF, 32'h0F1E_2D3C);
      // R9 abort with unread data pending
      slv_load(32'hA500_0000);
      apb_wr(8'h18, 32'h11);
      wait_idle();
      apb_rd(8'h04, d); check("R9 pending before abort", d, 32'h07);
      slv_load(32'h0);
      apb_wr(8'h14, 32'h5555_5555);
      repeat (10) @(negedge clk);
      apb_wr(8'h10, 32'h0);
      @(negedge clk);
      check("R9 sclk low", {31'b0, spi_sclk}, 32'h0);
      check("R9 cs high", {31'b0, spi_cs_n}, 32'h1);
      apb_rd(8'h04, d); check("R9 status after abort", d, 32'h0B);
      apb_wr(8'h10, 32'h1);
      // R10 overflow, R11 irq
      slv_load(32'h0);
      apb_wr(8'h18, 32'hA5);
      apb_wr(8'h1C, 32'hFFFF);
      apb_rd(8'h04, d); check("R10 overflow while busy", d, 32'h18);
      wait_idle();
      check("R10 second write ignored", 32'(slv_cnt), 32'h8);
      apb_rd(8'h24, d);
      apb_wr(8'h0C, 32'h10);
      @(negedge clk); check("R11 irq on overflow", {31'b0, irq}, 32'h1);
      apb_wr(8'h04, 32'h0F);
      apb_rd(8'h04, d); check("R10 live bits not cleared", d, 32'h1B);
      apb_wr(8'h04, 32'h10);
      apb_rd(8'h04, d); check("R10 w1c clears", d, 32'h0B);
      check("R11 irq clear", {31'b0, irq}, 32'h0);
      apb_wr(8'h0C, 32'h04);
      slv_load(32'h0);
      apb_wr(8'h18, 32'h3);
      wait_idle();
      @(negedge clk); check("R11 irq rx ready", {31'b0, irq}, 32'h1);
      apb_wr(8'h08, 32'h0B);
      @(negedge clk); check("R11 irq masked by sts_en", {31'b0, irq}, 32'h0);
      apb_wr(8'h08, 32'h1F);
      apb_rd(8'h24, d);
      @(negedge clk); check("R11 irq after pop", {31'b0, irq}, 32'h0);
      wait (act_q.size() == 0);
      #1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule